// File: doc/BRIEF.md
# Secure Line Erase Engine

This block sits between a host processor and a directly addressable non-volatile memory. Each erase request names a logical line. The engine looks that line up in a small logical-to-physical table that it holds itself. It then reads the eight stored words as a snapshot and overwrites them with random words. Finally it reads the line back and reports whether the old content is really gone. The random words either come from an internal 32-bit LFSR or arrive with the request as a 256-bit line supplied by the host.

Requests and responses are valid/ready streams. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the response has been consumed, so exactly one request is in flight. The response is offered on `rsp_valid`. It holds, with a stable status, for as long as the host keeps `rsp_ready` low. The table is programmed through a plain write port. The memory port is a simple enable/write-enable port with read data returned one cycle after a read is issued.

Top module: `secure_erase_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. After an accepted request it is low on the next cycle and stays low until the response handshake, and the memory port is idle whenever `req_ready` is high.
- R2: The accepted logical line is translated through the table, and every memory access of the request uses `mem_addr = pline*8 + w`, where `pline` is the table entry and `w` is the word index.
- R3: A request to a logical line whose table entry is invalid responds with status 2'b01 (not found) and makes no memory access. After reset every entry is invalid.
- R4: With `req_host_rand`=0, the written words come from a 32-bit LFSR. The LFSR starts at the seed 32'hACE12468 after reset. Each written word is the current state, and the state then advances by `s' = (s >> 1) ^ (s[0] ? 32'h80200003 : 0)`. The state carries on across requests.
- R5: With `req_host_rand`=1, word w written is `req_line[32*w +: 32]` as captured at acceptance, and the LFSR does not advance.
- R6: An LFSR-mode request while `media_inplace` is 0 responds with status 2'b11 (refused) and makes no memory access. Host-supplied mode is unaffected by `media_inplace`.
- R7: A found, non-refused request makes exactly 24 accesses in this order: 8 reads of words 0..7, then 8 writes of words 0..7, then 8 reads of words 0..7.
- R8: The status is 2'b10 (verify fail) if any readback word equals the snapshot word at the same index, or differs from the word written there. Otherwise it is 2'b00 (ok).
- R9: `rsp_valid` stays high and `rsp_status` stays stable until the cycle where `rsp_ready` is high.
- R10: The table entry stays valid after an erase, so a repeated request to the same logical line is served again on the same physical line.
- R11: `map_we` writes entry `map_laddr` with `{map_valid, map_pline}`. The new entry governs every request accepted after that edge.
- R12: During and right after reset, `req_ready` is 1 and `rsp_valid` and `mem_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Table entry write strobe |
| map_laddr | input | 3 | Logical line of the entry to write |
| map_pline | input | 4 | Physical line stored in the entry |
| map_valid | input | 1 | Valid bit stored in the entry |
| media_inplace | input | 1 | Memory can be overwritten in place; enables LFSR mode |
| req_valid | input | 1 | Erase request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_laddr | input | 3 | Logical line to erase |
| req_host_rand | input | 1 | 1: use req_line as random data; 0: use the LFSR |
| req_line | input | 256 | Host-supplied random line, word w at bits 32*w+31:32*w |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_status | output | 2 | 00 ok, 01 not found, 10 verify fail, 11 refused |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 7 | Word address {pline, word} |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The hardest outcome to reach from the ports is a verify failure, because a healthy memory always returns exactly what was written. The bench's memory model can be set to drop writes, so the readback equals the snapshot. It can also invert bit 0 of every read, so the readback differs from what was written. Separately, a host-supplied line is built to repeat one stored word. This reaches the equality branch with a correct memory. Every accepted request is swept over all logical lines in both random modes, and the bench predicts the status and the full 24-access log from its own table model, memory copy and LFSR arithmetic.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [1:0] {
    ST_OK       = 2'b00,
    ST_NOTFOUND = 2'b01,
    ST_VFAIL    = 2'b10,
    ST_REFUSED  = 2'b11
  } erase_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_SNAP,
    S_WRITE,
    S_VERIFY,
    S_DRAIN,
    S_RESP
  } erase_state_e;

  localparam logic [31:0] LFSR_TAPS_32 = 32'h80200003;
  localparam logic [31:0] LFSR_SEED_32 = 32'hACE12468;

endpackage

// File: rtl/erase_lfsr.sv
module erase_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'hACE12468,
  parameter logic [W-1:0] TAPS = 32'h80200003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (step) begin
      state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end
  end

  assign value = state_q;

endmodule

// File: rtl/erase_map.sv
module erase_map #(
  parameter int LA_W = 3,
  parameter int PL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [LA_W-1:0] wr_idx,
  input  logic [PL_W-1:0] wr_pline,
  input  logic            wr_valid,
  input  logic [LA_W-1:0] rd_idx,
  output logic            rd_valid,
  output logic [PL_W-1:0] rd_pline
);

  localparam int ENTRIES = 1 << LA_W;

  logic [ENTRIES-1:0] valid_q;
  logic [PL_W-1:0]    pline_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        pline_q[e] <= '0;
      end else if (wr_en && (wr_idx == LA_W'(e))) begin
        valid_q[e] <= wr_valid;
        pline_q[e] <= wr_pline;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_pline = pline_q[rd_idx];

endmodule

// File: rtl/erase_linebuf.sv
module erase_linebuf #(
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     old_we,
  input  logic [$clog2(WORDS)-1:0] old_idx,
  input  logic [DW-1:0]            old_data,
  input  logic                     new_we,
  input  logic [$clog2(WORDS)-1:0] new_idx,
  input  logic [DW-1:0]            new_data,
  input  logic [$clog2(WORDS)-1:0] chk_idx,
  input  logic [DW-1:0]            chk_data,
  output logic                     chk_bad
);

  localparam int WI_W = $clog2(WORDS);

  logic [DW-1:0] old_q [WORDS];
  logic [DW-1:0] new_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (old_we && (old_idx == WI_W'(w))) old_q[w] <= old_data;
      if (new_we && (new_idx == WI_W'(w))) new_q[w] <= new_data;
    end
  end

  // A readback word is bad if the old word survived or the new word did not land.
  assign chk_bad = (chk_data == old_q[chk_idx]) || (chk_data != new_q[chk_idx]);

endmodule

// File: rtl/secure_erase_engine.sv
module secure_erase_engine
  import erase_pkg::*;
#(
  parameter int LA_W  = 3,
  parameter int PL_W  = 4,
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  map_we,
  input  logic [LA_W-1:0]       map_laddr,
  input  logic [PL_W-1:0]       map_pline,
  input  logic                  map_valid,
  input  logic                  media_inplace,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LA_W-1:0]       req_laddr,
  input  logic                  req_host_rand,
  input  logic [WORDS*DW-1:0]   req_line,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_status,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [PL_W+$clog2(WORDS)-1:0] mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata
);

  localparam int WI_W   = $clog2(WORDS);
  localparam int LINE_W = WORDS * DW;

  erase_state_e    state_q;
  logic [LA_W-1:0] laddr_q;
  logic            host_q;
  logic [LINE_W-1:0] line_q;
  logic [PL_W-1:0] pline_q;
  logic [WI_W-1:0] cnt_q;
  logic            rd_pend_q;
  logic            rd_verify_q;
  logic [WI_W-1:0] rd_idx_q;
  logic            fail_q;
  erase_status_e   status_q;

  logic            map_hit;
  logic [PL_W-1:0] map_pl;
  logic [DW-1:0]   rnd_word;
  logic [DW-1:0]   wr_word;
  logic            lfsr_step;
  logic            chk_bad;
  logic            bad_now;
  logic            last_word;

  erase_map #(.LA_W(LA_W), .PL_W(PL_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_we),
    .wr_idx   (map_laddr),
    .wr_pline (map_pline),
    .wr_valid (map_valid),
    .rd_idx   (laddr_q),
    .rd_valid (map_hit),
    .rd_pline (map_pl)
  );

  erase_lfsr #(.W(DW), .SEED(LFSR_SEED_32), .TAPS(LFSR_TAPS_32)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (lfsr_step),
    .value (rnd_word)
  );

  erase_linebuf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk      (clk),
    .old_we   (rd_pend_q && !rd_verify_q),
    .old_idx  (rd_idx_q),
    .old_data (mem_rdata),
    .new_we   (state_q == S_WRITE),
    .new_idx  (cnt_q),
    .new_data (wr_word),
    .chk_idx  (rd_idx_q),
    .chk_data (mem_rdata),
    .chk_bad  (chk_bad)
  );

  always_comb begin
    wr_word   = host_q ? line_q[cnt_q*DW +: DW] : rnd_word;
    lfsr_step = (state_q == S_WRITE) && !host_q;
    bad_now   = rd_pend_q && rd_verify_q && chk_bad;
    last_word = (cnt_q == WI_W'(WORDS - 1));
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;
  assign mem_en     = (state_q == S_SNAP) || (state_q == S_WRITE) || (state_q == S_VERIFY);
  assign mem_we     = (state_q == S_WRITE);
  assign mem_addr   = {pline_q, cnt_q};
  assign mem_wdata  = wr_word;

  // Read return tracking: data of a read issued this cycle arrives next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q   <= 1'b0;
      rd_verify_q <= 1'b0;
      rd_idx_q    <= '0;
    end else begin
      rd_pend_q   <= (state_q == S_SNAP) || (state_q == S_VERIFY);
      rd_verify_q <= (state_q == S_VERIFY);
      rd_idx_q    <= cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      laddr_q  <= '0;
      host_q   <= 1'b0;
      line_q   <= '0;
      pline_q  <= '0;
      cnt_q    <= '0;
      fail_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            laddr_q <= req_laddr;
            host_q  <= req_host_rand;
            line_q  <= req_line;
            state_q <= S_LOOKUP;
          end
        end
        S_LOOKUP: begin
          cnt_q  <= '0;
          fail_q <= 1'b0;
          if (!map_hit) begin
            status_q <= ST_NOTFOUND;
            state_q  <= S_RESP;
          end else if (!host_q && !media_inplace) begin
            status_q <= ST_REFUSED;
            state_q  <= S_RESP;
          end else begin
            pline_q <= map_pl;
            state_q <= S_SNAP;
          end
        end
        S_SNAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_word) state_q <= S_WRITE;
        end
        S_WRITE: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_word) state_q <= S_VERIFY;
        end
        S_VERIFY: begin
          cnt_q  <= cnt_q + 1'b1;
          fail_q <= fail_q | bad_now;
          if (last_word) state_q <= S_DRAIN;
        end
        S_DRAIN: begin
          status_q <= (fail_q || bad_now) ? ST_VFAIL : ST_OK;
          state_q  <= S_RESP;
        end
        S_RESP: begin
          if (rsp_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/erase_engine_chk.sv
module erase_engine_chk
  import erase_pkg::*;
#(
  parameter int WORDS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_status,
  input logic       mem_en,
  input logic       mem_we
);

  localparam int CW = $clog2(2 * WORDS + 1) + 1;

  logic [CW-1:0] wcnt_q;
  logic [CW-1:0] rcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (req_valid && req_ready) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (mem_en) begin
      if (mem_we) wcnt_q <= wcnt_q + 1'b1;
      else        rcnt_q <= rcnt_q + 1'b1;
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

  a_r3_notfound_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_NOTFOUND) |-> (wcnt_q == '0 && rcnt_q == '0));

  a_r6_refused_noaccess: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_REFUSED) |-> (wcnt_q == '0 && rcnt_q == '0));

  a_r7_full_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status == ST_OK || rsp_status == ST_VFAIL))
      |-> (wcnt_q == CW'(WORDS) && rcnt_q == CW'(2 * WORDS)));

  a_r7_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

endmodule

bind secure_erase_engine erase_engine_chk #(.WORDS(WORDS)) u_erase_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .mem_en     (mem_en),
  .mem_we     (mem_we)
);

// File: tb/tb_secure_erase_engine.sv
`timescale 1ns/1ps
module tb_secure_erase_engine;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         map_we = 1'b0;
  logic [2:0]   map_laddr = '0;
  logic [3:0]   map_pline = '0;
  logic         map_valid = 1'b0;
  logic         media_inplace = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_laddr = '0;
  logic         req_host_rand = 1'b0;
  logic [255:0] req_line = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [1:0]   rsp_status;
  logic         mem_en;
  logic         mem_we;
  logic [6:0]   mem_addr;
  logic [31:0]  mem_wdata;
  logic [31:0]  mem_rdata;

  always #2 clk = ~clk;

  secure_erase_engine dut (
    .clk(clk), .rst_n(rst_n),
    .map_we(map_we), .map_laddr(map_laddr), .map_pline(map_pline), .map_valid(map_valid),
    .media_inplace(media_inplace),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .req_host_rand(req_host_rand), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model with fault injection, plus an access log.
  logic        drop_writes = 1'b0;
  logic        flip_reads  = 1'b0;
  logic [31:0] arr [0:127];
  logic        log_we   [0:2047];
  logic [6:0]  log_addr [0:2047];
  logic [31:0] log_data [0:2047];
  int          op_total = 0;

  function automatic logic [31:0] init_word(input int i);
    return 32'hC0DE0000 ^ (i * 32'h01000193);
  endfunction

  function automatic logic [31:0] lnext(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) arr[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      log_we[op_total % 2048]   <= mem_we;
      log_addr[op_total % 2048] <= mem_addr;
      log_data[op_total % 2048] <= mem_wdata;
      op_total <= op_total + 1;
      if (mem_we) begin
        if (!drop_writes) arr[mem_addr] <= mem_wdata;
      end else begin
        mem_rdata <= arr[mem_addr] ^ {31'b0, flip_reads};
      end
    end
  end

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_lfsr = 32'hACE12468;
  logic        mv [0:7];
  logic [3:0]  mp [0:7];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_map(input int la, input bit v, input int pl);
    @(negedge clk);
    map_we = 1'b1; map_laddr = 3'(la); map_valid = v; map_pline = 4'(pl);
    @(negedge clk);
    map_we = 1'b0;
    mv[la] = v; mp[la] = 4'(pl);
  endtask

  task automatic do_req(input int la, input bit host, input logic [255:0] line, input string req);
    logic [31:0] oldw [8];
    logic [31:0] neww [8];
    logic [31:0] s;
    logic [1:0]  exp_st;
    logic [1:0]  st0;
    bit          full;
    bit          seq_ok;
    int          start, n, base, bad_i;
    s = exp_lfsr;
    base = 8 * int'(mp[la]);
    for (int k = 0; k < 8; k++) begin
      oldw[k] = arr[base + k];
      neww[k] = host ? line[32*k +: 32] : s;
      s = lnext(s);
    end
    if (!mv[la])                         exp_st = 2'b01;
    else if (!host && !media_inplace)    exp_st = 2'b11;
    else if (drop_writes || flip_reads)  exp_st = 2'b10;
    else begin
      exp_st = 2'b00;
      for (int k = 0; k < 8; k++) if (oldw[k] == neww[k]) exp_st = 2'b10;
    end
    full = (exp_st == 2'b00) || (exp_st == 2'b10);

    @(negedge clk);
    req_valid = 1'b1; req_laddr = 3'(la); req_host_rand = host; req_line = line;
    start = op_total;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready low after accept", 32'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, req, "response arrived", 32'(rsp_valid), 1);
    st0 = rsp_status;
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_status == st0, "R9", "response held under back-pressure",
        {31'b0, rsp_valid}, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(st0 == exp_st, req, "status", 32'(st0), 32'(exp_st));
    n = op_total - start;
    chk(n == (full ? 24 : 0), req, "access count", 32'(n), full ? 24 : 0);
    if (full && n == 24) begin
      seq_ok = 1'b1; bad_i = -1;
      for (int i = 0; i < 24; i++) begin
        int j = (start + i) % 2048;
        int w = i % 8;
        bit ew = (i >= 8 && i < 16);
        if (log_we[j] != ew || int'(log_addr[j]) != base + w ||
            (ew && log_data[j] != neww[w])) begin
          if (seq_ok) bad_i = i;
          seq_ok = 1'b0;
        end
      end
      // R2 addresses, R4/R5 data, R7 order are all covered by this log comparison.
      chk(seq_ok, req, "R2 R7 access log (first bad index in actual)", 32'(bad_i), 32'hFFFFFFFF);
    end
    if (full && !host) exp_lfsr = s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    logic [255:0] ln;
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; mp[i] = '0; end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1, "R12", "req_ready in reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0 && mem_en == 1'b0, "R12", "rsp_valid/mem_en in reset",
        {30'b0, rsp_valid, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_en == 1'b0, "R12", "idle after reset", {30'b0, req_ready, mem_en}, 2);

    // R3: empty table answers not found
    do_req(0, 1'b0, '0, "R3");

    // R11: program table; laddr 6 stays invalid
    for (int la = 0; la < 8; la++) set_map(la, la != 6, (la * 5 + 3) % 16);

    // R4: LFSR mode sweep over every logical line (R3 on line 6)
    for (int la = 0; la < 8; la++) do_req(la, 1'b0, '0, la == 6 ? "R3" : "R4");

    // R5: host-supplied sweep
    for (int la = 0; la < 8; la++) begin
      for (int k = 0; k < 8; k++) ln[32*k +: 32] = 32'hB0000000 | (la << 8) | k;
      do_req(la, 1'b1, ln, la == 6 ? "R3" : "R5");
    end

    // R10: erased entries remain mapped; LFSR continues across requests (R4)
    for (int la = 0; la < 8; la++) do_req(la, 1'b0, '0, la == 6 ? "R3" : "R10");

    // R6: LFSR mode refused without in-place media; host mode still served
    media_inplace = 1'b0;
    do_req(1, 1'b0, '0, "R6");
    for (int k = 0; k < 8; k++) ln[32*k +: 32] = 32'hD1000000 | k;
    do_req(1, 1'b1, ln, "R6");
    media_inplace = 1'b1;

    // R8: host line repeats a stored word -> verify fail with a healthy memory
    for (int k = 0; k < 8; k++) ln[32*k +: 32] = 32'hE2000000 | k;
    ln[32*3 +: 32] = arr[8 * int'(mp[2]) + 3];
    do_req(2, 1'b1, ln, "R8");

    // R8: memory drops writes -> readback equals snapshot
    drop_writes = 1'b1;
    do_req(3, 1'b0, '0, "R8");
    drop_writes = 1'b0;

    // R8: memory corrupts reads -> readback differs from written
    flip_reads = 1'b1;
    for (int k = 0; k < 8; k++) ln[32*k +: 32] = 32'hF3000000 | k;
    do_req(4, 1'b1, ln, "R8");
    flip_reads = 1'b0;

    // R11: remap and invalidate take effect on the next request
    set_map(5, 1'b1, 15);
    do_req(5, 1'b0, '0, "R11");
    set_map(0, 1'b0, 0);
    do_req(0, 1'b0, '0, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule